// File: doc/BRIEF.md
# Page-Splitting DMA Descriptor Generator

This block takes one transfer request and turns it into a chain of DMA descriptors. A request is a start address, a byte length and a direction. No descriptor in the chain spans two pages. Each descriptor has a command code, a byte count and an address. Physical addresses equal the request addresses. The chain always ends with a terminating stop descriptor. A descriptor engine, or any other sink, reads the chain one entry at a time over a valid/ready port.

A request enters through a start handshake. The block accepts a new request only when it is idle. After the stop descriptor is taken, a one-cycle done pulse marks the end of the chain. A request that spans too many pages produces no descriptors. Instead, the error output pulses for one cycle.

Top module: `dma_page_splitter`

## Requirements
- R1: After reset, `start_ready` is 1 and `desc_valid`, `done` and `err` are all 0.
- R2: No data descriptor crosses a page boundary. If the start address is not page-aligned and the transfer runs past the end of that page, the first descriptor covers only the bytes up to the page end.
- R3: While more than one page of the request remains, each further descriptor covers exactly one full page and starts on a page boundary.
- R4: The final data descriptor carries everything that remains (at most one page) and uses a LAST code. Every earlier data descriptor uses a MORE code.
- R5: The direction input picks the code family. `req_dir_in`=0 gives OUT_MORE=0 and OUT_LAST=1. `req_dir_in`=1 gives IN_MORE=2 and IN_LAST=3.
- R6: After the last data descriptor comes a stop descriptor with code 7, count 0 and address 0. `done` is 1 for exactly the one cycle after the stop descriptor is accepted.
- R7: A request is illegal when its length divided by the page size (integer division) exceeds `MAX_PAGES`. For an illegal request, `err` is 1 for exactly the cycle after acceptance. No descriptor is produced, `done` stays 0 and `start_ready` stays 1.
- R8: A request that ends inside or exactly at the end of its first page produces a single LAST descriptor with the full length, followed by the stop descriptor.
- R9: One descriptor is consumed per accepted handshake. While `desc_ready` is 0, the offered descriptor holds steady. Start requests made while a chain is in progress are ignored.
- R10: A zero-length request produces one LAST descriptor with count 0 at the start address, followed by the stop descriptor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_valid | input | 1 | A request is presented |
| start_ready | output | 1 | Block is idle and can take a request |
| req_addr | input | 32 | Start byte address |
| req_len | input | 18 | Transfer length in bytes |
| req_dir_in | input | 1 | 1 = device-to-memory (IN family), 0 = OUT family |
| desc_valid | output | 1 | A descriptor is offered |
| desc_ready | input | 1 | Sink accepts the offered descriptor |
| desc_cmd | output | 3 | Descriptor command code |
| desc_count | output | 13 | Descriptor byte count |
| desc_addr | output | 32 | Descriptor byte address |
| done | output | 1 | One-cycle pulse after the stop descriptor is accepted |
| err | output | 1 | One-cycle pulse for an illegal request |

## Verification
The end of one chain and the start of the next can happen in the same cycle. In the cycle where `done` pulses, `start_ready` has just returned to 1, so a waiting request is accepted in that very cycle. The bench holds `start_valid` high with a second request for the whole of the first chain. It then checks three things: the first chain is unaffected, `done` lasts exactly one cycle, and the second request is taken on the done cycle and produces its own correct chain.

// File: rtl/dps_pkg.sv
// Package: shared descriptor command codes for the page splitter.
// Assumes a 3-bit command field; bit 1 selects the IN family, bit 0 marks LAST.
package dps_pkg;
    typedef enum logic [2:0] {
        DC_OUT_MORE = 3'd0,
        DC_OUT_LAST = 3'd1,
        DC_IN_MORE  = 3'd2,
        DC_IN_LAST  = 3'd3,
        DC_STOP     = 3'd7
    } desc_cmd_e;
endpackage

// File: rtl/dps_req_check.sv
// Module: legality check for a request length.
// Flags a request whose whole-page count is larger than MAX_PAGES.
// Assumes PAGE_BYTES is a power of two.
module dps_req_check #(
    parameter int LEN_W      = 18,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_PAGES  = 32
) (
    input  logic [LEN_W-1:0] req_len,
    output logic             illegal
);
    localparam int OFS_W = $clog2(PAGE_BYTES);

    // Compare the integer page count against the limit.
    always_comb begin
        illegal = (req_len >> OFS_W) > LEN_W'(MAX_PAGES);
    end
endmodule

// File: rtl/dps_chunk_calc.sv
// Module: works out the next data descriptor from the running position.
// The chunk runs to the page end, or covers all that remains if that is less.
// Assumes PAGE_BYTES is a power of two and LEN_W is at least OFS_W+1.
module dps_chunk_calc import dps_pkg::*; #(
    parameter int LEN_W      = 18,
    parameter int PAGE_BYTES = 4096,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = OFS_W + 1
) (
    input  logic [OFS_W-1:0] page_ofs,
    input  logic [LEN_W-1:0] remain,
    input  logic             dir_in,
    output desc_cmd_e        cmd,
    output logic [CNT_W-1:0] count,
    output logic             is_last
);
    logic [CNT_W-1:0] room;

    // Bytes left before the next page boundary, and the chunk size.
    always_comb begin
        room    = CNT_W'(PAGE_BYTES) - CNT_W'(page_ofs);
        is_last = remain <= LEN_W'(room);
        count   = is_last ? remain[CNT_W-1:0] : room;
    end

    // Pick the command code from direction and position in the chain.
    always_comb begin
        unique case ({dir_in, is_last})
            2'b00:   cmd = DC_OUT_MORE;
            2'b01:   cmd = DC_OUT_LAST;
            2'b10:   cmd = DC_IN_MORE;
            default: cmd = DC_IN_LAST;
        endcase
    end
endmodule

// File: rtl/dps_seq.sv
// Module: chain sequencer. Takes a request, walks through the data chunks
// one handshake at a time, then offers the stop descriptor and pulses done.
// Assumes the chunk calculator is combinational on the current position.
module dps_seq import dps_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 18,
    parameter int PAGE_BYTES = 4096,
    localparam int OFS_W     = $clog2(PAGE_BYTES),
    localparam int CNT_W     = OFS_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    output logic              start_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_dir_in,
    input  logic              req_illegal,
    output logic [OFS_W-1:0]  cur_ofs,
    output logic [LEN_W-1:0]  cur_remain,
    output logic              cur_dir_in,
    input  desc_cmd_e         chunk_cmd,
    input  logic [CNT_W-1:0]  chunk_count,
    input  logic              chunk_last,
    output logic              desc_valid,
    input  logic              desc_ready,
    output desc_cmd_e         desc_cmd,
    output logic [CNT_W-1:0]  desc_count,
    output logic [ADDR_W-1:0] desc_addr,
    output logic              done,
    output logic              err
);
    typedef enum logic [1:0] {S_IDLE, S_DATA, S_STOP} seq_state_e;

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  remain_q;
    logic              dir_q;
    logic              done_q;
    logic              err_q;

    // State, position and the one-cycle done/error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            addr_q   <= '0;
            remain_q <= '0;
            dir_q    <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= 1'b0;
            unique case (state_q)
                S_IDLE: begin
                    if (start_valid) begin
                        if (req_illegal) begin
                            err_q <= 1'b1;
                        end else begin
                            addr_q   <= req_addr;
                            remain_q <= req_len;
                            dir_q    <= req_dir_in;
                            state_q  <= S_DATA;
                        end
                    end
                end
                S_DATA: begin
                    if (desc_ready) begin
                        addr_q   <= addr_q + ADDR_W'(chunk_count);
                        remain_q <= remain_q - LEN_W'(chunk_count);
                        if (chunk_last) state_q <= S_STOP;
                    end
                end
                default: begin
                    if (desc_ready) begin
                        state_q <= S_IDLE;
                        done_q  <= 1'b1;
                    end
                end
            endcase
        end
    end

    // Descriptor port: data chunk in S_DATA, zeroed stop entry in S_STOP.
    always_comb begin
        start_ready = (state_q == S_IDLE);
        desc_valid  = (state_q != S_IDLE);
        desc_cmd    = (state_q == S_STOP) ? DC_STOP : chunk_cmd;
        desc_count  = (state_q == S_STOP) ? '0 : chunk_count;
        desc_addr   = (state_q == S_STOP) ? '0 : addr_q;
        cur_ofs     = addr_q[OFS_W-1:0];
        cur_remain  = remain_q;
        cur_dir_in  = dir_q;
        done        = done_q;
        err         = err_q;
    end

    AST_NO_PAGE_CROSS: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_cmd != DC_STOP) |->
        (int'(desc_addr[OFS_W-1:0]) + int'(desc_count) <= PAGE_BYTES)); // R2

    AST_MORE_ENDS_ON_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && (desc_cmd == DC_OUT_MORE || desc_cmd == DC_IN_MORE)) |->
        (OFS_W'(desc_addr[OFS_W-1:0] + desc_count[OFS_W-1:0]) == '0)); // R3

    AST_DIR_FAMILY: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_cmd != DC_STOP) |-> (desc_cmd[1] == dir_q)); // R5

    AST_STOP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && (desc_cmd == DC_OUT_LAST || desc_cmd == DC_IN_LAST))
        |=> (desc_valid && desc_cmd == DC_STOP)); // R6

    AST_DONE_AFTER_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && desc_ready && desc_cmd == DC_STOP) |=> (done && !desc_valid)); // R6

    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!desc_valid && !done && start_ready)); // R7

    AST_HOLD_WHEN_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
        (desc_valid && !desc_ready) |=>
        (desc_valid && $stable(desc_cmd) && $stable(desc_count) && $stable(desc_addr))); // R9
endmodule

// File: rtl/dma_page_splitter.sv
// Module: top of the page-splitting DMA descriptor generator.
// Wires the legality check, the chunk calculator and the sequencer.
// Assumes PAGE_BYTES is a power of two and identity address translation.
module dma_page_splitter import dps_pkg::*; #(
    parameter int ADDR_W     = 32,
    parameter int LEN_W      = 18,
    parameter int PAGE_BYTES = 4096,
    parameter int MAX_PAGES  = 32
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_valid,
    output logic                       start_ready,
    input  logic [ADDR_W-1:0]          req_addr,
    input  logic [LEN_W-1:0]           req_len,
    input  logic                       req_dir_in,
    output logic                       desc_valid,
    input  logic                       desc_ready,
    output logic [2:0]                 desc_cmd,
    output logic [$clog2(PAGE_BYTES):0] desc_count,
    output logic [ADDR_W-1:0]          desc_addr,
    output logic                       done,
    output logic                       err
);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int CNT_W = OFS_W + 1;

    logic             illegal;
    logic [OFS_W-1:0] cur_ofs;
    logic [LEN_W-1:0] cur_remain;
    logic             cur_dir_in;
    desc_cmd_e        chunk_cmd;
    logic [CNT_W-1:0] chunk_count;
    logic             chunk_last;
    desc_cmd_e        seq_cmd;

    dps_req_check #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES), .MAX_PAGES(MAX_PAGES)) u_check (
        .req_len (req_len),
        .illegal (illegal)
    );

    dps_chunk_calc #(.LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_chunk (
        .page_ofs (cur_ofs),
        .remain   (cur_remain),
        .dir_in   (cur_dir_in),
        .cmd      (chunk_cmd),
        .count    (chunk_count),
        .is_last  (chunk_last)
    );

    dps_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .PAGE_BYTES(PAGE_BYTES)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_valid (start_valid),
        .start_ready (start_ready),
        .req_addr    (req_addr),
        .req_len     (req_len),
        .req_dir_in  (req_dir_in),
        .req_illegal (illegal),
        .cur_ofs     (cur_ofs),
        .cur_remain  (cur_remain),
        .cur_dir_in  (cur_dir_in),
        .chunk_cmd   (chunk_cmd),
        .chunk_count (chunk_count),
        .chunk_last  (chunk_last),
        .desc_valid  (desc_valid),
        .desc_ready  (desc_ready),
        .desc_cmd    (seq_cmd),
        .desc_count  (desc_count),
        .desc_addr   (desc_addr),
        .done        (done),
        .err         (err)
    );

    // Present the command as a plain 3-bit code at the boundary.
    always_comb desc_cmd = seq_cmd;
endmodule

// File: tb/dma_page_splitter_bench.sv
`timescale 1ns/1ps
module dma_page_splitter_bench;
    localparam int PAGE = 4096;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_valid = 1'b0;
    logic        start_ready;
    logic [31:0] req_addr = '0;
    logic [17:0] req_len = '0;
    logic        req_dir_in = 1'b0;
    logic        desc_valid;
    logic        desc_ready = 1'b0;
    logic [2:0]  desc_cmd;
    logic [12:0] desc_count;
    logic [31:0] desc_addr;
    logic        done;
    logic        err;

    int applied = 0;
    int bad = 0;

    int          exp_n;
    logic [2:0]  exp_cmd  [0:63];
    logic [12:0] exp_cnt  [0:63];
    logic [31:0] exp_addr [0:63];

    always #2.5 clk = ~clk;

    dma_page_splitter u_dma_page_splitter (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
        .req_addr(req_addr), .req_len(req_len), .req_dir_in(req_dir_in),
        .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_cmd(desc_cmd),
        .desc_count(desc_count), .desc_addr(desc_addr), .done(done), .err(err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        applied++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // Reference chain built from the requirements (R2 R3 R4 R5 R6 R10).
    task automatic build_exp(input logic [31:0] a0, input int len, input bit din);
        logic [31:0] a;
        int c;
        int ofs;
        a = a0; c = len; exp_n = 0;
        ofs = int'(a0 % PAGE);
        if (ofs != 0 && c > PAGE - ofs) begin
            exp_cmd[exp_n] = din ? 3'd2 : 3'd0; exp_cnt[exp_n] = 13'(PAGE - ofs);
            exp_addr[exp_n] = a; exp_n++;
            c = c - (PAGE - ofs); a = a + 32'(PAGE - ofs);
        end
        while (c > PAGE) begin
            exp_cmd[exp_n] = din ? 3'd2 : 3'd0; exp_cnt[exp_n] = 13'(PAGE);
            exp_addr[exp_n] = a; exp_n++;
            c = c - PAGE; a = a + 32'(PAGE);
        end
        exp_cmd[exp_n] = din ? 3'd3 : 3'd1; exp_cnt[exp_n] = 13'(c);
        exp_addr[exp_n] = a; exp_n++;
        exp_cmd[exp_n] = 3'd7; exp_cnt[exp_n] = '0; exp_addr[exp_n] = '0; exp_n++;
    endtask

    task automatic send(input logic [31:0] a, input int len, input bit din);
        int guard;
        guard = 0;
        while (!start_ready && guard < 1000) begin @(negedge clk); guard++; end
        req_addr = a; req_len = 18'(len); req_dir_in = din; start_valid = 1'b1;
        @(negedge clk);
        start_valid = 1'b0;
    endtask

    // Sink: consume the chain, compare each entry, check holds under stall.
    task automatic drain(input logic [31:0] a, input int len, input bit din,
                         input bit stall, input string req);
        int i;
        int cyc;
        bit held;
        logic [47:0] snap;
        logic [47:0] now;
        build_exp(a, len, din);
        i = 0; cyc = 0; held = 0; snap = '0;
        while (i < exp_n && cyc < 3000) begin
            desc_ready = stall ? ((cyc % 3) == 2) : 1'b1;
            now = {desc_cmd, desc_count, desc_addr};
            if (desc_valid && desc_ready) begin
                chk(now == {exp_cmd[i], exp_cnt[i], exp_addr[i]}, req, "descriptor",
                    longint'(now), longint'({exp_cmd[i], exp_cnt[i], exp_addr[i]}));
                i++;
            end else if (desc_valid) begin
                held = 1; snap = now;
            end
            @(negedge clk);
            if (held) begin
                chk({desc_cmd, desc_count, desc_addr} == snap, "R9", "held descriptor",
                    longint'({desc_cmd, desc_count, desc_addr}), longint'(snap));
                held = 0;
            end
            cyc++;
        end
        desc_ready = 1'b0;
        chk(i == exp_n, req, "descriptors consumed", i, exp_n);
    endtask

    task automatic done_pulse;
        chk(done == 1'b1, "R6", "done after stop", done, 1);
        @(negedge clk);
        chk(done == 1'b0, "R6", "done one cycle", done, 0);
    endtask

    task automatic t_reset;
        chk(start_ready == 1'b1 && !desc_valid && !done && !err, "R1", "reset outputs",
            {start_ready, desc_valid, done, err}, 4'b1000);
    endtask

    task automatic t_aligned;
        send(32'h0001_0000, 3 * PAGE, 1'b0);
        drain(32'h0001_0000, 3 * PAGE, 1'b0, 1'b0, "R3");
        done_pulse();
    endtask

    task automatic t_unaligned_span;
        send(32'h0000_1F00, 'h2300, 1'b1);
        drain(32'h0000_1F00, 'h2300, 1'b1, 1'b0, "R2");
        done_pulse();
        send(32'h0000_6800, 'h1000, 1'b0);
        drain(32'h0000_6800, 'h1000, 1'b0, 1'b0, "R5");
        done_pulse();
    endtask

    task automatic t_fit;
        send(32'h0000_5010, 'h20, 1'b0);
        drain(32'h0000_5010, 'h20, 1'b0, 1'b0, "R8");
        done_pulse();
        send(32'h0000_5F00, 'h100, 1'b1);
        drain(32'h0000_5F00, 'h100, 1'b1, 1'b0, "R8");
        done_pulse();
    endtask

    task automatic t_stall;
        send(32'h0000_7FF0, 'h1020, 1'b1);
        drain(32'h0000_7FF0, 'h1020, 1'b1, 1'b1, "R9");
        done_pulse();
    endtask

    task automatic t_illegal;
        send(32'h0000_0000, 33 * PAGE, 1'b0);
        chk(err == 1'b1, "R7", "err pulse", err, 1);
        chk(!desc_valid && start_ready, "R7", "no chain, ready",
            {desc_valid, start_ready}, 2'b01);
        @(negedge clk);
        chk(err == 1'b0, "R7", "err one cycle", err, 0);
        for (int k = 0; k < 4; k++) begin
            chk(!desc_valid && !done, "R7", "quiet after illegal", {desc_valid, done}, 0);
            @(negedge clk);
        end
        send(32'h0000_0000, 33 * PAGE - 1, 1'b0);
        drain(32'h0000_0000, 33 * PAGE - 1, 1'b0, 1'b0, "R4");
        done_pulse();
    endtask

    task automatic t_zero;
        send(32'h0000_3004, 0, 1'b1);
        drain(32'h0000_3004, 0, 1'b1, 1'b0, "R10");
        done_pulse();
    endtask

    // Second request held on start during the first chain; taken on the done cycle.
    task automatic t_overlap;
        int guard;
        guard = 0;
        while (!start_ready && guard < 100) begin @(negedge clk); guard++; end
        req_addr = 32'h0000_2000; req_len = 18'h1800; req_dir_in = 1'b0; start_valid = 1'b1;
        @(negedge clk);
        req_addr = 32'h0000_A0F0; req_len = 18'h30; req_dir_in = 1'b1;
        drain(32'h0000_2000, 'h1800, 1'b0, 1'b0, "R9");
        chk(done && start_ready, "R6", "done with ready", {done, start_ready}, 2'b11);
        @(negedge clk);
        start_valid = 1'b0;
        chk(!done && !start_ready, "R9", "second request taken", {done, start_ready}, 2'b00);
        drain(32'h0000_A0F0, 'h30, 1'b1, 1'b0, "R9");
        done_pulse();
    endtask

    initial begin
        #(5.0 * 150000);
        bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_aligned();
        t_unaligned_span();
        t_fit();
        t_stall();
        t_illegal();
        t_zero();
        t_overlap();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", applied, bad);
        $finish;
    end
endmodule